// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block orders the conversions of a sigma-delta converter across a multiplexed set of analog inputs. A small write-only configuration port sets the mux topology (three fully differential inputs or five pseudo-differential inputs), the channel for on-demand work, continuous scanning, the gain code, the offset-DAC code and the unipolar/bipolar range. The gain, offset and range values are passed straight to the analog front end. The block itself does not use them.

In on-demand mode, a request pulse starts one conversion on the selected channel. In scan mode, the block cycles through every input that exists in the current topology and then the offset-calibration and gain-calibration channels, and it repeats this without stopping. After each channel switch it pulses a restart to the decimation filter. It then drops filter words until one is flagged settled and emits that word tagged with a 3-bit channel identifier. Any configuration write cancels the conversion in flight.

The controller is a four-state machine:
- ST_IDLE leaves to ST_SWITCH when scan is enabled (cursor set to 0), or when a request arrives in on-demand mode (cursor set to the sanitised selection).
- ST_SWITCH always leaves to ST_SETTLE.
- ST_SETTLE stays until a valid, settled filter word arrives, then leaves to ST_EMIT.
- ST_EMIT leaves to ST_SWITCH with the next channel in scan mode, or to ST_IDLE in on-demand mode.
- A configuration write forces ST_IDLE from any state.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, all of the following are 0: busy, flt_restart, res_valid, fe_chan, fe_pseudo, fe_gain, fe_offset and fe_unipolar. In this state, on-demand mode is active with the differential topology, channel 0, gain code 0 (lowest gain), offset code 0 (no offset) and bipolar range.
- R2: A write updates the front-end outputs one cycle after its clock edge. The register map is:
  - address 0: bit0 scan enable, bit1 pseudo topology (fe_pseudo).
  - address 1: bits[2:0] channel selection.
  - address 2: bits[2:0] gain code (fe_gain).
  - address 3: bits[3:0] offset code (fe_offset).
  - address 4: bit0 unipolar (fe_unipolar).
  - addresses 5 to 7: ignored entirely. They change no output and abort nothing.
- R3: In on-demand mode, a conv_req sampled while idle makes busy go high and flt_restart pulse in the following cycle, with fe_chan holding the selected channel.
- R4: Filter words presented with flt_settled low are dropped. The first word presented with flt_valid and flt_settled both high appears one cycle later as a single res_valid cycle, with res_data equal to that word and res_chan equal to the converted channel.
- R5: In on-demand mode, exactly one result is produced per request, after which the block is idle. A conv_req while busy is ignored.
- R6: In scan mode with the differential topology, the channel order is 0, 1, 2, 6, 7 and then back to 0.
- R7: In scan mode with the pseudo topology, the channel order is 0, 1, 2, 3, 4, 6, 7 and then back to 0.
- R8: Identifier 6 is offset calibration and 7 is gain calibration. A selection that does not exist in the current topology is converted on channel 0: that is 3, 4 or 5 in the differential topology, and 5 in the pseudo topology.
- R9: A write to addresses 0 to 4 abandons the conversion in progress, and no result is produced for it. busy is low in the cycle after the write. In scan mode, a new restart on channel 0 follows one cycle later.
- R10: flt_restart and res_valid are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| conv_req | input | 1 | On-demand conversion request |
| flt_valid | input | 1 | Filter word present |
| flt_settled | input | 1 | Filter reports the word is settled |
| flt_data | input | DATA_W | Filter output word |
| flt_restart | output | 1 | One-cycle filter restart after a channel switch |
| fe_chan | output | 3 | Channel driven to the input mux |
| fe_pseudo | output | 1 | Mux topology: 1 = five pseudo-differential inputs |
| fe_gain | output | 3 | Gain code to the front end |
| fe_offset | output | 4 | Offset-DAC code to the front end |
| fe_unipolar | output | 1 | Range select: 1 = unipolar |
| busy | output | 1 | A conversion is in flight |
| res_valid | output | 1 | Tagged result valid |
| res_data | output | DATA_W | Result word |
| res_chan | output | 3 | Channel identifier of the result |

## Verification
The hardest case to reach is a configuration write that lands while the block is waiting for a settled word in the middle of a scan. The bench has to drive the scan into the settle state of a non-zero channel and feed it unsettled words so that it is still waiting. It then writes, checks that the abandoned word never appears, and checks that the sequence restarts on channel 0. The same approach is used to show that a reserved-address write during a pending conversion changes nothing, and that the topology-dependent remapping of illegal selections takes effect in both mux modes.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    localparam int CFG_ADDR_W = 3;
    localparam int CFG_DATA_W = 8;
    localparam int CHAN_W     = 3;
    localparam int NUM_IDS    = 1 << CHAN_W;

    localparam logic [CFG_ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [CFG_ADDR_W-1:0] A_CHSEL = 3'd1;
    localparam logic [CFG_ADDR_W-1:0] A_GAIN  = 3'd2;
    localparam logic [CFG_ADDR_W-1:0] A_OFFS  = 3'd3;
    localparam logic [CFG_ADDR_W-1:0] A_RANGE = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_SETTLE,
        ST_EMIT
    } seq_state_e;

    typedef struct packed {
        logic              scan;
        logic              pseudo;
        logic [CHAN_W-1:0] sel;
        logic [2:0]        gain;
        logic [3:0]        offs;
        logic              unipolar;
    } seq_cfg_t;

endpackage

// File: rtl/scanseq_regfile.sv
module scanseq_regfile
    import scanseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [CFG_DATA_W-1:0] wr_data,
    output seq_cfg_t              cfg,
    output logic                  cfg_wr
);

    logic wdata_unused;
    assign wdata_unused = ^wr_data[CFG_DATA_W-1:4];

    // Only the five mapped addresses count as configuration writes.
    assign cfg_wr = wr_en && (wr_addr <= A_RANGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            unique case (wr_addr)
                A_MODE: begin
                    cfg.scan   <= wr_data[0];
                    cfg.pseudo <= wr_data[1];
                end
                A_CHSEL: cfg.sel      <= wr_data[CHAN_W-1:0];
                A_GAIN:  cfg.gain     <= wr_data[2:0];
                A_OFFS:  cfg.offs     <= wr_data[3:0];
                A_RANGE: cfg.unipolar <= wr_data[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/scanseq_chan_map.sv
module scanseq_chan_map
    import scanseq_pkg::*;
#(
    parameter int DIFF_CH     = 3,
    parameter int PSEUDO_CH   = 5,
    parameter int CAL_OFF_ID  = 6,
    parameter int CAL_GAIN_ID = 7
) (
    input  logic              pseudo,
    input  logic [CHAN_W-1:0] cur_chan,
    input  logic [CHAN_W-1:0] sel,
    output logic [CHAN_W-1:0] next_chan,
    output logic [CHAN_W-1:0] sel_chan
);

    localparam logic [CHAN_W:0]   N_DIFF = (CHAN_W+1)'(DIFF_CH);
    localparam logic [CHAN_W:0]   N_PSD  = (CHAN_W+1)'(PSEUDO_CH);
    localparam logic [CHAN_W-1:0] ID_OFF = CHAN_W'(CAL_OFF_ID);
    localparam logic [CHAN_W-1:0] ID_GN  = CHAN_W'(CAL_GAIN_ID);

    logic [CHAN_W:0]    n_inputs;
    logic [NUM_IDS-1:0] legal;

    assign n_inputs = pseudo ? N_PSD : N_DIFF;

    // One legality bit per identifier: a physical input of the current
    // topology, or one of the two calibration channels.
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_legal
        assign legal[i] = ((CHAN_W+1)'(i) < n_inputs) ||
                          (i == CAL_OFF_ID) || (i == CAL_GAIN_ID);
    end

    assign sel_chan = legal[sel] ? sel : '0;

    always_comb begin
        if (cur_chan == ID_GN) begin
            next_chan = '0;
        end else if (cur_chan == ID_OFF) begin
            next_chan = ID_GN;
        end else if (({1'b0, cur_chan} + 1'b1) < n_inputs) begin
            next_chan = cur_chan + 1'b1;
        end else begin
            next_chan = ID_OFF;
        end
    end

endmodule

// File: rtl/scanseq_fsm.sv
module scanseq_fsm
    import scanseq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              scan,
    input  logic              conv_req,
    input  logic              flt_valid,
    input  logic              flt_settled,
    input  logic [DATA_W-1:0] flt_data,
    input  logic [CHAN_W-1:0] next_chan,
    input  logic [CHAN_W-1:0] sel_chan,
    output logic [CHAN_W-1:0] cur_chan,
    output logic              flt_restart,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan
);

    seq_state_e        state, state_nx;
    logic              settled_hit;
    logic [DATA_W-1:0] data_q;
    logic [CHAN_W-1:0] tag_q;

    assign settled_hit = flt_valid && flt_settled;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: a configuration write overrides every state.
    always_comb begin
        state_nx = state;
        if (cfg_wr) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (scan || conv_req) state_nx = ST_SWITCH;
                ST_SWITCH: state_nx = ST_SETTLE;
                ST_SETTLE: if (settled_hit) state_nx = ST_EMIT;
                ST_EMIT:   state_nx = scan ? ST_SWITCH : ST_IDLE;
            endcase
        end
    end

    // Channel cursor and captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_chan <= '0;
            data_q   <= '0;
            tag_q    <= '0;
        end else if (cfg_wr) begin
            cur_chan <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (scan)          cur_chan <= '0;
                    else if (conv_req) cur_chan <= sel_chan;
                end
                ST_SETTLE: begin
                    if (settled_hit) begin
                        data_q <= flt_data;
                        tag_q  <= cur_chan;
                    end
                end
                ST_EMIT: if (scan) cur_chan <= next_chan;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        flt_restart = 1'b0;
        res_valid   = 1'b0;
        busy        = 1'b1;
        unique case (state)
            ST_IDLE:   busy        = 1'b0;
            ST_SWITCH: flt_restart = 1'b1;
            ST_SETTLE: ;
            ST_EMIT:   res_valid   = 1'b1;
        endcase
        res_data = data_q;
        res_chan = tag_q;
    end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scanseq_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int DIFF_CH     = 3,
    parameter int PSEUDO_CH   = 5,
    parameter int CAL_OFF_ID  = 6,
    parameter int CAL_GAIN_ID = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              conv_req,
    input  logic              flt_valid,
    input  logic              flt_settled,
    input  logic [DATA_W-1:0] flt_data,
    output logic              flt_restart,
    output logic [2:0]        fe_chan,
    output logic              fe_pseudo,
    output logic [2:0]        fe_gain,
    output logic [3:0]        fe_offset,
    output logic              fe_unipolar,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [2:0]        res_chan
);

    seq_cfg_t          cfg;
    logic              cfg_wr;
    logic [CHAN_W-1:0] cur_chan;
    logic [CHAN_W-1:0] next_chan;
    logic [CHAN_W-1:0] sel_chan;

    scanseq_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .cfg_wr  (cfg_wr)
    );

    scanseq_chan_map #(
        .DIFF_CH     (DIFF_CH),
        .PSEUDO_CH   (PSEUDO_CH),
        .CAL_OFF_ID  (CAL_OFF_ID),
        .CAL_GAIN_ID (CAL_GAIN_ID)
    ) u_map (
        .pseudo    (cfg.pseudo),
        .cur_chan  (cur_chan),
        .sel       (cfg.sel),
        .next_chan (next_chan),
        .sel_chan  (sel_chan)
    );

    scanseq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .scan        (cfg.scan),
        .conv_req    (conv_req),
        .flt_valid   (flt_valid),
        .flt_settled (flt_settled),
        .flt_data    (flt_data),
        .next_chan   (next_chan),
        .sel_chan    (sel_chan),
        .cur_chan    (cur_chan),
        .flt_restart (flt_restart),
        .busy        (busy),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .res_chan    (res_chan)
    );

    assign fe_chan     = cur_chan;
    assign fe_pseudo   = cfg.pseudo;
    assign fe_gain     = cfg.gain;
    assign fe_offset   = cfg.offs;
    assign fe_unipolar = cfg.unipolar;

endmodule

// File: rtl/scanseq_checker.sv
module scanseq_checker #(
    parameter int DATA_W    = 24,
    parameter int DIFF_CH   = 3,
    parameter int PSEUDO_CH = 5,
    parameter int CAL_LOW   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              flt_restart,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [2:0]        res_chan,
    input logic [2:0]        fe_chan,
    input logic              fe_pseudo,
    input logic              flt_valid,
    input logic              flt_settled,
    input logic [DATA_W-1:0] flt_data
);

    // R10
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_restart |=> !flt_restart);

    // R10
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4
    settled_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(flt_valid && flt_settled));

    // R4
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data == $past(flt_data)));

    // R4
    tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan == fe_chan));

    // R3
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> flt_restart);

    // R8
    legal_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((32'(fe_chan) >= CAL_LOW) ||
                  (32'(fe_chan) < (fe_pseudo ? PSEUDO_CH : DIFF_CH))));

endmodule

bind scan_sequencer scanseq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .flt_restart (flt_restart),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .fe_chan     (fe_chan),
    .fe_pseudo   (fe_pseudo),
    .flt_valid   (flt_valid),
    .flt_settled (flt_settled),
    .flt_data    (flt_data)
);

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        conv_req = 1'b0;
    logic        flt_valid = 1'b0;
    logic        flt_settled = 1'b0;
    logic [23:0] flt_data = '0;
    logic        flt_restart, fe_pseudo, fe_unipolar, busy, res_valid;
    logic [2:0]  fe_chan, fe_gain, res_chan;
    logic [3:0]  fe_offset;
    logic [23:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    scan_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conv_req(conv_req), .flt_valid(flt_valid),
        .flt_settled(flt_settled), .flt_data(flt_data),
        .flt_restart(flt_restart), .fe_chan(fe_chan), .fe_pseudo(fe_pseudo),
        .fe_gain(fe_gain), .fe_offset(fe_offset), .fe_unipolar(fe_unipolar),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic request();
        conv_req = 1'b1;
        step();
        conv_req = 1'b0;
    endtask

    task automatic present(input logic [23:0] d, input logic settled);
        flt_valid = 1'b1; flt_settled = settled; flt_data = d;
        step();
        flt_valid = 1'b0; flt_settled = 1'b0;
    endtask

    // Entered at the negedge of a switch cycle; leaves one cycle after emit.
    task automatic convert(input string tag, input logic [2:0] ch,
                           input logic [23:0] d, input int n_drop);
        chk({tag, " restart"}, flt_restart, 1);
        chk({tag, " channel"}, fe_chan, ch);
        step();
        chk({tag, " restart low"}, flt_restart, 0);
        for (int k = 0; k < n_drop; k++) begin
            present(~d, 1'b0);
            chk({tag, " R4 drop unsettled"}, res_valid, 0);
        end
        present(d, 1'b1);
        chk({tag, " R4 valid"}, res_valid, 1);
        chk({tag, " R4 data"}, res_data, d);
        chk({tag, " R4 tag"}, res_chan, ch);
        step();
    endtask

    task automatic test_reset();
        chk("R1 busy", busy, 0);
        chk("R1 restart", flt_restart, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 fe_chan", fe_chan, 0);
        chk("R1 pseudo", fe_pseudo, 0);
        chk("R1 gain", fe_gain, 0);
        chk("R1 offset", fe_offset, 0);
        chk("R1 unipolar", fe_unipolar, 0);
    endtask

    task automatic test_regs();
        wr(3'd2, 8'h05);  chk("R2 gain", fe_gain, 5);
        wr(3'd3, 8'h0A);  chk("R2 offset", fe_offset, 4'hA);
        wr(3'd4, 8'h01);  chk("R2 unipolar", fe_unipolar, 1);
        wr(3'd0, 8'h02);  chk("R2 pseudo", fe_pseudo, 1);
        wr(3'd0, 8'h00);  chk("R2 pseudo off", fe_pseudo, 0);
        wr(3'd5, 8'hFF);
        chk("R2 reserved gain", fe_gain, 5);
        chk("R2 reserved offset", fe_offset, 4'hA);
        chk("R2 reserved range", fe_unipolar, 1);
        chk("R2 reserved busy", busy, 0);
        wr(3'd4, 8'h00);
    endtask

    task automatic test_single();
        wr(3'd1, 8'h02);
        request();
        chk("R3 restart", flt_restart, 1);
        chk("R3 channel", fe_chan, 2);
        chk("R3 busy", busy, 1);
        step();
        conv_req = 1'b1;
        step();
        conv_req = 1'b0;
        chk("R5 request ignored", flt_restart, 0);
        chk("R5 still busy", busy, 1);
        present(24'h111111, 1'b0);
        chk("R4 drop 1", res_valid, 0);
        present(24'h222222, 1'b0);
        chk("R4 drop 2", res_valid, 0);
        present(24'hABCDEF, 1'b1);
        chk("R4 valid", res_valid, 1);
        chk("R4 data", res_data, 24'hABCDEF);
        chk("R4 tag", res_chan, 2);
        step();
        chk("R5 idle", busy, 0);
        chk("R5 single pulse", res_valid, 0);
    endtask

    task automatic test_remap();
        wr(3'd1, 8'h04); request(); convert("R8 diff sel4", 3'd0, 24'h000401, 0);
        wr(3'd1, 8'h07); request(); convert("R8 gain cal", 3'd7, 24'h000701, 1);
        wr(3'd0, 8'h02);
        wr(3'd1, 8'h04); request(); convert("R8 pseudo sel4", 3'd4, 24'h000402, 0);
        wr(3'd1, 8'h05); request(); convert("R8 pseudo sel5", 3'd0, 24'h000502, 0);
        wr(3'd0, 8'h00);
        chk("R8 idle", busy, 0);
    endtask

    task automatic test_abort_single();
        wr(3'd1, 8'h01);
        request();
        chk("R3 chan1", fe_chan, 1);
        step();
        wr(3'd6, 8'hFF);
        chk("R2 reserved no abort", busy, 1);
        present(24'h0C0FFE, 1'b1);
        chk("R2 reserved result", res_valid, 1);
        chk("R2 reserved data", res_data, 24'h0C0FFE);
        step();
        request();
        step();
        wr(3'd2, 8'h03);
        chk("R9 abort busy", busy, 0);
        chk("R9 gain", fe_gain, 3);
        present(24'hDEAD01, 1'b1);
        chk("R9 no result", res_valid, 0);
        step();
        chk("R9 stays idle", busy, 0);
        chk("R9 no restart", flt_restart, 0);
    endtask

    task automatic test_scan();
        wr(3'd0, 8'h01);
        chk("R9 idle after write", busy, 0);
        step();
        convert("R6 c0", 3'd0, 24'h600000, 1);
        convert("R6 c1", 3'd1, 24'h600001, 0);
        convert("R6 c2", 3'd2, 24'h600002, 2);
        convert("R6 c6", 3'd6, 24'h600006, 0);
        convert("R6 c7", 3'd7, 24'h600007, 1);
        convert("R6 wrap", 3'd0, 24'h600010, 0);
        wr(3'd0, 8'h03);
        step();
        convert("R7 c0", 3'd0, 24'h700000, 0);
        convert("R7 c1", 3'd1, 24'h700001, 1);
        convert("R7 c2", 3'd2, 24'h700002, 0);
        convert("R7 c3", 3'd3, 24'h700003, 0);
        convert("R7 c4", 3'd4, 24'h700004, 2);
        convert("R7 c6", 3'd6, 24'h700006, 0);
        convert("R7 c7", 3'd7, 24'h700007, 0);
        convert("R7 wrap", 3'd0, 24'h700010, 0);
        chk("R9 pre-abort chan", fe_chan, 1);
        step();
        present(24'h123456, 1'b0);
        wr(3'd3, 8'h05);
        chk("R9 scan abort busy", busy, 0);
        chk("R9 offset", fe_offset, 5);
        chk("R9 no result", res_valid, 0);
        step();
        chk("R9 restart", flt_restart, 1);
        chk("R9 restart chan0", fe_chan, 0);
        wr(3'd0, 8'h00);
        step();
        chk("R9 scan off idle", busy, 0);
        chk("R9 scan off restart", flt_restart, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regs();
        test_single();
        test_remap();
        test_abort_single();
        test_scan();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule